// File: doc/BRIEF.md
# Receive Packet Filter with Status Appending

This block sits behind the byte synchroniser of a packet radio receiver. It is armed by a pulse that marks a detected sync word and then takes the de-whitened bytes that follow, one per `byteValid` strobe. It decides which of them reach the receive FIFO, and it writes them through a one-byte write port. The framing can be a fixed length, a length taken from the first byte, or no length at all. A packet can be dropped for an oversize length byte or for a wrong destination address. The block checks a 16-bit CRC and can pulse a flush of the whole FIFO when that check fails. It can also write two status bytes after a good payload, built from the RSSI and link-quality values supplied on its inputs.

Bytes are expected at most once every four clock cycles, which matches serial byte rates. Every output is registered and changes one cycle after the strobe that causes it. Dropping a packet raises `restartSearch` so that the upstream sync search starts again. The block then ignores bytes until the next sync pulse. The end of every completed packet is marked by `pktDone`, issued together with the last FIFO write or with the flush.

Top module: `rxflt_top`

## Requirements
- R1: While reset is active and in the first cycle after it, `fifoWrEn`, `fifoFlush`, `restartSearch` and `pktDone` are all 0.
- R2: With `lenMode` = 1 (variable), the first byte after sync is the payload length L. It is written to the FIFO, followed by exactly L payload bytes. When `crcEn` is 1, the two CRC bytes that follow are consumed but never written.
- R3: In variable mode, a length byte greater than the allowed maximum drops the packet. `restartSearch` pulses, nothing of the packet is written, and later bytes are ignored until the next sync pulse.
- R4: In variable mode with `autoFlush` = 1, the allowed maximum is the smaller of `pktLen` and FIFO_DEPTH−1 (63). When `appendStatus` is also 1, the limit is FIFO_DEPTH−3 (61) instead. Without `autoFlush`, the limit is `pktLen`.
- R5: With `lenMode` = 0 (fixed), exactly `pktLen` bytes follow sync and are written, with the address byte (if checked) counted as the first of them.
- R6: `addrMode` 0 performs no address check. Mode 1 accepts only `nodeAddr`. Mode 2 also accepts 0x00, and mode 3 accepts both 0x00 and 0xFF. A mismatch drops the packet with a `restartSearch` pulse, and the length byte is then not written either.
- R7: With `lenMode` = 2 or 3 (unbounded), no end is ever reached and every byte is written. If the address matches, the FIFO receives 0xFF, then the address byte, then the payload.
- R8: The CRC is CRC-16 with polynomial 0x8005, initial value 0xFFFF, bits MSB first. It covers every byte after sync, including the two received CRC bytes, and passes when the remainder is zero. With `autoFlush` = 1, a failed check pulses `fifoFlush` and writes no status bytes.
- R9: With `appendStatus` = 1, a completed packet that is not flushed is followed by two written bytes. The first is `rssi`. The second has bit 7 = CRC pass (1 when `crcEn` = 0) and bits 6:0 = `lqi`.
- R10: `pktDone` pulses exactly once per completed packet: with the last FIFO write, or with `fifoFlush`. It never pulses for a dropped or unbounded packet.
- R11: A sync pulse in the middle of a packet abandons it and starts framing a new packet, with the CRC restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| syncFound | input | 1 | One-cycle pulse: sync word detected, new packet begins |
| byteValid | input | 1 | Strobe for a received byte |
| byteData | input | 8 | Received, de-whitened byte |
| lenMode | input | 2 | 0 fixed, 1 variable, 2/3 unbounded |
| pktLen | input | 8 | Fixed length, or maximum length in variable mode |
| addrMode | input | 2 | Address filter mode 0..3 |
| nodeAddr | input | 8 | This node's address |
| crcEn | input | 1 | CRC bytes present and checked |
| autoFlush | input | 1 | Flush FIFO on CRC failure |
| appendStatus | input | 1 | Append two status bytes |
| rssi | input | 8 | Signal strength value for status byte 1 |
| lqi | input | 7 | Link quality value for status byte 2 |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | 8 | FIFO write data |
| fifoFlush | output | 1 | Pulse: flush the entire receive FIFO |
| restartSearch | output | 1 | Pulse: packet dropped, restart sync search |
| pktDone | output | 1 | Pulse: packet completed |

## Verification
The hardest cases to reach are those where two FIFO writes are owed for a single received byte. This happens in variable mode with address filtering, where the held length byte and the address go out together. It also happens when that address byte is the last payload byte of a one-byte packet with status appending, so the two writes run straight into the two status bytes. Directed packets with L = 1 and matching addresses reach this case. The length limits of R4 are probed on both sides of 61 and 63. A mid-packet re-sync checks that the partial writes are followed by a clean new packet. Seeded random packets then mix all framing, address, CRC and status settings, including corrupted CRCs and addresses that are neither broadcast nor the node's own.

// File: rtl/rxflt_pkg.sv
package rxflt_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEN, ST_ADR, ST_PAY, ST_CRC1, ST_CRC2
  } ctrlState_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_PAIR, SQ_ST1, SQ_ST2
  } seqState_e;

  // strobes from control to datapath, valid in the cycle of byteValid/syncFound
  typedef struct packed {
    logic              crcInit;
    logic              crcUpd;
    logic              wrByte;   // write the incoming byte
    logic              wrPair;   // write pairHead, then the incoming byte
    logic [BYTE_W-1:0] pairHead;
    logic              endPkt;   // incoming byte closes the packet
    logic              drop;     // packet discarded
  } ctrlStb_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] d,
                                               input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ d[i]) r = {r[CRC_W-2:0], 1'b0} ^ poly;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/rxflt_ctrl.sv
module rxflt_ctrl
  import rxflt_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncFound,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [1:0]        lenMode,
  input  logic [BYTE_W-1:0] pktLen,
  input  logic [1:0]        addrMode,
  input  logic [BYTE_W-1:0] nodeAddr,
  input  logic              crcEn,
  input  logic              autoFlush,
  input  logic              appendStatus,
  output ctrlStb_t          stb
);
  localparam logic [BYTE_W-1:0] CAP_PLAIN = BYTE_W'(FIFO_DEPTH - 1);
  localparam logic [BYTE_W-1:0] CAP_STAT  = BYTE_W'(FIFO_DEPTH - 3);

  ctrlState_e        state, nState;
  logic [BYTE_W-1:0] cnt, nCnt;
  logic [BYTE_W-1:0] lenHold;
  logic [BYTE_W-1:0] capLen, maxLen;
  logic              isVar, isUnb, adrOn, adrHit;

  assign isVar  = (lenMode == 2'd1);
  assign isUnb  = lenMode[1];
  assign adrOn  = (addrMode != 2'd0);
  assign capLen = appendStatus ? CAP_STAT : CAP_PLAIN;
  assign maxLen = (autoFlush && (capLen < pktLen)) ? capLen : pktLen;
  assign adrHit = (byteData == nodeAddr)
               || (addrMode[1] && (byteData == '0))
               || ((addrMode == 2'd3) && (byteData == '1));

  always_comb begin
    stb    = '0;
    nState = state;
    nCnt   = cnt;
    if (syncFound) begin
      stb.crcInit = 1'b1;
      nCnt        = pktLen;
      nState      = isVar ? ST_LEN : (adrOn ? ST_ADR : ST_PAY);
    end else if (byteValid) begin
      unique case (state)
        ST_LEN: begin
          stb.crcUpd = 1'b1;
          nCnt       = byteData;
          if (byteData > maxLen) begin
            stb.drop = 1'b1;
            nState   = ST_IDLE;
          end else if (byteData == '0) begin
            stb.wrByte = 1'b1;
            if (crcEn) nState = ST_CRC1;
            else begin
              stb.endPkt = 1'b1;
              nState     = ST_IDLE;
            end
          end else if (adrOn) begin
            nState = ST_ADR;
          end else begin
            stb.wrByte = 1'b1;
            nState     = ST_PAY;
          end
        end
        ST_ADR: begin
          stb.crcUpd = 1'b1;
          if (!adrHit) begin
            stb.drop = 1'b1;
            nState   = ST_IDLE;
          end else if (isUnb) begin
            stb.wrPair   = 1'b1;
            stb.pairHead = '1;
            nState       = ST_PAY;
          end else begin
            if (isVar) begin
              stb.wrPair   = 1'b1;
              stb.pairHead = lenHold;
            end else begin
              stb.wrByte = 1'b1;
            end
            nCnt = cnt - 1'b1;
            if (cnt == BYTE_W'(1)) begin
              if (crcEn) nState = ST_CRC1;
              else begin
                stb.endPkt = 1'b1;
                nState     = ST_IDLE;
              end
            end else begin
              nState = ST_PAY;
            end
          end
        end
        ST_PAY: begin
          stb.crcUpd = 1'b1;
          stb.wrByte = 1'b1;
          if (!isUnb) begin
            nCnt = cnt - 1'b1;
            if (cnt == BYTE_W'(1)) begin
              if (crcEn) nState = ST_CRC1;
              else begin
                stb.endPkt = 1'b1;
                nState     = ST_IDLE;
              end
            end
          end
        end
        ST_CRC1: begin
          stb.crcUpd = 1'b1;
          nState     = ST_CRC2;
        end
        ST_CRC2: begin
          stb.crcUpd = 1'b1;
          stb.endPkt = 1'b1;
          nState     = ST_IDLE;
        end
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      lenHold <= '0;
    end else begin
      state <= nState;
      cnt   <= nCnt;
      if (byteValid && !syncFound && (state == ST_LEN)) lenHold <= byteData;
    end
  end
endmodule

// File: rtl/rxflt_dp.sv
module rxflt_dp
  import rxflt_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8005,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              crcEn,
  input  logic              autoFlush,
  input  logic              appendStatus,
  input  logic [BYTE_W-1:0] rssi,
  input  logic [BYTE_W-2:0] lqi,
  output logic              fifoWrEn,
  output logic [BYTE_W-1:0] fifoWrData,
  output logic              fifoFlush,
  output logic              restartSearch,
  output logic              pktDone
);
  logic [CRC_W-1:0]  crcReg, crcNext;
  logic              crcGood;
  seqState_e         seq;
  logic [BYTE_W-1:0] pairByte;
  logic              endPend, okLatch;

  assign crcNext = crcStep(crcReg, byteData, CRC_POLY);
  assign crcGood = !crcEn || (crcNext == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) crcReg <= CRC_INIT;
    else if (stb.crcInit) crcReg <= CRC_INIT;
    else if (stb.crcUpd)  crcReg <= crcNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoWrEn      <= 1'b0;
      fifoWrData    <= '0;
      fifoFlush     <= 1'b0;
      restartSearch <= 1'b0;
      pktDone       <= 1'b0;
      seq           <= SQ_IDLE;
      pairByte      <= '0;
      endPend       <= 1'b0;
      okLatch       <= 1'b0;
    end else begin
      fifoWrEn      <= 1'b0;
      fifoFlush     <= 1'b0;
      pktDone       <= 1'b0;
      restartSearch <= stb.drop;
      if (stb.wrPair) begin
        fifoWrEn   <= 1'b1;
        fifoWrData <= stb.pairHead;
        pairByte   <= byteData;
        endPend    <= stb.endPkt;
        okLatch    <= crcGood;
        seq        <= SQ_PAIR;
      end else if (stb.wrByte) begin
        fifoWrEn   <= 1'b1;
        fifoWrData <= byteData;
        if (stb.endPkt) begin
          okLatch <= crcGood;
          if (appendStatus) seq <= SQ_ST1;
          else              pktDone <= 1'b1;
        end
      end else if (stb.endPkt) begin
        okLatch <= crcGood;
        if (crcEn && autoFlush && !crcGood) begin
          fifoFlush <= 1'b1;
          pktDone   <= 1'b1;
        end else if (appendStatus) begin
          fifoWrEn   <= 1'b1;
          fifoWrData <= rssi;
          seq        <= SQ_ST2;
        end else begin
          pktDone <= 1'b1;
        end
      end else begin
        unique case (seq)
          SQ_PAIR: begin
            fifoWrEn   <= 1'b1;
            fifoWrData <= pairByte;
            if (endPend && appendStatus) seq <= SQ_ST1;
            else begin
              pktDone <= endPend;
              seq     <= SQ_IDLE;
            end
          end
          SQ_ST1: begin
            fifoWrEn   <= 1'b1;
            fifoWrData <= rssi;
            seq        <= SQ_ST2;
          end
          SQ_ST2: begin
            fifoWrEn   <= 1'b1;
            fifoWrData <= {okLatch, lqi};
            pktDone    <= 1'b1;
            seq        <= SQ_IDLE;
          end
          default: seq <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxflt_top.sv
module rxflt_top
  import rxflt_pkg::*;
#(
  parameter int                FIFO_DEPTH = 64,
  parameter logic [CRC_W-1:0]  CRC_POLY   = 16'h8005,
  parameter logic [CRC_W-1:0]  CRC_INIT   = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncFound,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic [1:0] lenMode,
  input  logic [7:0] pktLen,
  input  logic [1:0] addrMode,
  input  logic [7:0] nodeAddr,
  input  logic       crcEn,
  input  logic       autoFlush,
  input  logic       appendStatus,
  input  logic [7:0] rssi,
  input  logic [6:0] lqi,
  output logic       fifoWrEn,
  output logic [7:0] fifoWrData,
  output logic       fifoFlush,
  output logic       restartSearch,
  output logic       pktDone
);
  ctrlStb_t stbBus;

  rxflt_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .syncFound(syncFound), .byteValid(byteValid),
    .byteData(byteData), .lenMode(lenMode), .pktLen(pktLen),
    .addrMode(addrMode), .nodeAddr(nodeAddr), .crcEn(crcEn),
    .autoFlush(autoFlush), .appendStatus(appendStatus), .stb(stbBus)
  );

  rxflt_dp #(.CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stbBus), .byteData(byteData),
    .crcEn(crcEn), .autoFlush(autoFlush), .appendStatus(appendStatus),
    .rssi(rssi), .lqi(lqi), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .fifoFlush(fifoFlush), .restartSearch(restartSearch), .pktDone(pktDone)
  );
endmodule

// File: rtl/rxflt_chk.sv
module rxflt_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pairStb,
  input logic [7:0] byteData,
  input logic       appendStatus,
  input logic [7:0] rssi,
  input logic [6:0] lqi,
  input logic       fifoWrEn,
  input logic [7:0] fifoWrData,
  input logic       fifoFlush,
  input logic       restartSearch,
  input logic       pktDone
);
  // R3: a dropped packet writes nothing and is not reported as done
  a_r3_drop_silent: assert property (@(posedge clk) disable iff (!rstN)
    restartSearch |-> (!fifoWrEn && !pktDone));

  // R8: a flush closes the packet and carries no write
  a_r8_flush_is_done: assert property (@(posedge clk) disable iff (!rstN)
    fifoFlush |-> (pktDone && !fifoWrEn));

  // R7: the byte that triggered a double write reaches the FIFO two cycles later
  a_r7_pair_second: assert property (@(posedge clk) disable iff (!rstN)
    pairStb |=> ##1 (fifoWrEn && (fifoWrData == $past(byteData, 2))));

  // R9: the final status byte carries link quality, with RSSI just before it
  a_r9_status_tail: assert property (@(posedge clk) disable iff (!rstN)
    (pktDone && appendStatus && !fifoFlush) |->
      (fifoWrEn && (fifoWrData[6:0] == lqi)));

  a_r9_status_rssi: assert property (@(posedge clk) disable iff (!rstN)
    (pktDone && appendStatus && !fifoFlush) |->
      ($past(fifoWrEn) && ($past(fifoWrData) == $past(rssi))));

  // R10: completion and drop never coincide
  a_r10_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pktDone, restartSearch}));
endmodule

bind rxflt_top rxflt_chk u_chk (
  .clk(clk), .rstN(rstN), .pairStb(stbBus.wrPair), .byteData(byteData),
  .appendStatus(appendStatus), .rssi(rssi), .lqi(lqi),
  .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .fifoFlush(fifoFlush),
  .restartSearch(restartSearch), .pktDone(pktDone)
);

// File: tb/rxflt_top_tb.sv
module rxflt_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncFound = 1'b0, byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic [1:0] lenMode = '0, addrMode = '0;
  logic [7:0] pktLen = 8'd1, nodeAddr = 8'h5A;
  logic       crcEn = 1'b0, autoFlush = 1'b0, appendStatus = 1'b0;
  logic [7:0] rssi = 8'h00;
  logic [6:0] lqi = 7'h00;
  logic       fifoWrEn, fifoFlush, restartSearch, pktDone;
  logic [7:0] fifoWrData;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxflt_top u_dut (
    .clk(clk), .rstN(rstN), .syncFound(syncFound), .byteValid(byteValid),
    .byteData(byteData), .lenMode(lenMode), .pktLen(pktLen),
    .addrMode(addrMode), .nodeAddr(nodeAddr), .crcEn(crcEn),
    .autoFlush(autoFlush), .appendStatus(appendStatus), .rssi(rssi),
    .lqi(lqi), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .fifoFlush(fifoFlush), .restartSearch(restartSearch), .pktDone(pktDone)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [7:0] cap [0:511];
  int capN = 0, flushN = 0, restN = 0, doneN = 0;
  logic [7:0] exp [0:511];
  int expN, expFlush, expRest, expDone;
  logic [7:0] pk [0:511];
  int pkN;
  logic [7:0] adrByte;

  always @(negedge clk) begin
    if (rstN) begin
      if (fifoWrEn && capN < 512) begin cap[capN] = fifoWrData; capN++; end
      if (fifoFlush) flushN++;
      if (restartSearch) restN++;
      if (pktDone) doneN++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] benchCrc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        bit fb = c[15] ^ pk[i][b];
        c = c << 1;
        if (fb) c = c ^ 16'h8005;
      end
    return c;
  endfunction

  task automatic push(input logic [7:0] b);
    exp[expN] = b; expN++;
  endtask

  // expected FIFO traffic from the requirements
  task automatic buildExp();
    int idx = 0, cnt, l = 0, mx;
    bit isVar = (lenMode == 2'd1), unb = lenMode[1], ok, hit;
    logic [7:0] a;
    expN = 0; expFlush = 0; expRest = 0; expDone = 0;
    if (isVar) begin
      l = pk[0]; idx = 1; mx = pktLen;
      if (autoFlush) mx = (mx < (appendStatus ? 61 : 63)) ? mx : (appendStatus ? 61 : 63);
      if (l > mx) begin expRest = 1; return; end
      cnt = l;
      if (!(addrMode != 0 && l > 0)) push(8'(l));
    end else cnt = pktLen;
    if (addrMode != 0 && (unb || cnt > 0)) begin
      a = pk[idx]; idx++;
      hit = (a == nodeAddr) || (addrMode >= 2 && a == 8'h00) || (addrMode == 3 && a == 8'hFF);
      if (!hit) begin expRest = 1; return; end
      if (unb) push(8'hFF); else if (isVar) push(8'(l));
      push(a); cnt--;
    end
    if (unb) begin
      while (idx < pkN) begin push(pk[idx]); idx++; end
      return;
    end
    while (cnt > 0) begin push(pk[idx]); idx++; cnt--; end
    ok = 1;
    if (crcEn) ok = (benchCrc(idx + 2) == 16'h0000);
    expDone = 1;
    if (crcEn && autoFlush && !ok) begin expFlush = 1; return; end
    if (appendStatus) begin push(rssi); push({ok, lqi}); end
  endtask

  task automatic makePkt(input int payLen, input bit bad);
    int count;
    logic [15:0] c;
    pkN = 0;
    if (lenMode == 2'd1) begin pk[0] = 8'(payLen); pkN = 1; end
    count = (lenMode == 2'd0) ? int'(pktLen) : payLen;
    for (int j = 0; j < count; j++) begin
      pk[pkN] = (j == 0 && addrMode != 0) ? adrByte : 8'($urandom);
      pkN++;
    end
    if (crcEn && !lenMode[1]) begin
      c = benchCrc(pkN);
      pk[pkN] = c[15:8]; pk[pkN+1] = c[7:0]; pkN += 2;
      if (bad) pk[pkN-1] = pk[pkN-1] ^ 8'h01;
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteData = b;
    @(negedge clk); byteValid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendSync();
    @(negedge clk); syncFound = 1'b1;
    @(negedge clk); syncFound = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendPkt();
    sendSync();
    for (int i = 0; i < pkN; i++) sendByte(pk[i]);
    repeat (8) @(negedge clk);
  endtask

  task automatic clearCap();
    capN = 0; flushN = 0; restN = 0; doneN = 0;
  endtask

  task automatic compare(input string req);
    int mis = -1;
    check(capN == expN, req, "write count", capN, expN);
    for (int i = 0; i < expN && i < capN; i++)
      if (mis < 0 && cap[i] != exp[i]) mis = i;
    if (mis >= 0) check(0, req, $sformatf("write byte %0d", mis), cap[mis], exp[mis]);
    else          check(1, req, "write bytes", 0, 0);
    check(flushN == expFlush, "R8", "flush pulses", flushN, expFlush);
    check(restN == expRest, "R3", "restart pulses", restN, expRest);
    check(doneN == expDone, "R10", "done pulses", doneN, expDone);
  endtask

  task automatic runCase(input string req, input int payLen, input bit bad);
    makePkt(payLen, bad);
    buildExp();
    clearCap();
    sendPkt();
    compare(req);
  endtask

  task automatic setCfg(input logic [1:0] lm, input logic [7:0] pl, input logic [1:0] am,
                        input bit ce, input bit af, input bit ap);
    lenMode = lm; pktLen = pl; addrMode = am; crcEn = ce; autoFlush = af; appendStatus = ap;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1: reset state
    check({fifoWrEn, fifoFlush, restartSearch, pktDone} == 4'b0, "R1", "outputs in reset",
          {fifoWrEn, fifoFlush, restartSearch, pktDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({fifoWrEn, fifoFlush, restartSearch, pktDone} == 4'b0, "R1", "outputs after reset",
          {fifoWrEn, fifoFlush, restartSearch, pktDone}, 0);
    rssi = 8'hC3; lqi = 7'h2D; nodeAddr = 8'h5A;

    // R2: variable length with CRC, no address
    setCfg(2'd1, 8'd20, 2'd0, 1, 0, 0); runCase("R2", 5, 0);
    setCfg(2'd1, 8'd20, 2'd0, 1, 0, 0); runCase("R2", 0, 0);
    // R3: oversize length dropped, following bytes ignored
    setCfg(2'd1, 8'd4, 2'd0, 1, 0, 0); makePkt(9, 0); buildExp(); clearCap();
    sendPkt(); sendByte(8'h33); sendByte(8'h34); repeat (6) @(negedge clk); compare("R3");
    // R4: effective maximum with auto-flush
    setCfg(2'd1, 8'd200, 2'd0, 1, 1, 1); runCase("R4", 62, 0);
    setCfg(2'd1, 8'd200, 2'd0, 1, 1, 1); runCase("R4", 61, 0);
    setCfg(2'd1, 8'd200, 2'd0, 1, 1, 0); runCase("R4", 64, 0);
    setCfg(2'd1, 8'd200, 2'd0, 1, 1, 0); runCase("R4", 63, 0);
    setCfg(2'd1, 8'd200, 2'd0, 1, 0, 0); runCase("R4", 100, 0);
    // R5: fixed length with address first
    adrByte = 8'h5A; setCfg(2'd0, 8'd6, 2'd1, 1, 0, 0); runCase("R5", 0, 0);
    // R6: address modes
    adrByte = 8'h00; setCfg(2'd1, 8'd30, 2'd1, 1, 0, 0); runCase("R6", 4, 0);
    adrByte = 8'h00; setCfg(2'd1, 8'd30, 2'd2, 1, 0, 0); runCase("R6", 4, 0);
    adrByte = 8'hFF; setCfg(2'd1, 8'd30, 2'd2, 1, 0, 0); runCase("R6", 4, 0);
    adrByte = 8'hFF; setCfg(2'd1, 8'd30, 2'd3, 1, 0, 0); runCase("R6", 4, 0);
    adrByte = 8'h5A; setCfg(2'd1, 8'd30, 2'd1, 0, 0, 1); runCase("R6", 1, 0);
    // R7: unbounded with matching address
    adrByte = 8'h5A; setCfg(2'd2, 8'd10, 2'd1, 0, 0, 0); runCase("R7", 6, 0);
    // R8: bad CRC flushed; R9 bad CRC without flush shows flag 0
    setCfg(2'd1, 8'd30, 2'd0, 1, 1, 1); runCase("R8", 7, 1);
    setCfg(2'd1, 8'd30, 2'd0, 1, 0, 1); runCase("R9", 7, 1);
    setCfg(2'd1, 8'd30, 2'd0, 1, 1, 1); runCase("R9", 7, 0);
    // R11: resync in the middle of a packet
    setCfg(2'd1, 8'd30, 2'd0, 1, 0, 0);
    clearCap();
    sendSync(); sendByte(8'd5); sendByte(8'h11); sendByte(8'h22);
    makePkt(3, 0); buildExp();
    for (int i = expN - 1; i >= 0; i--) exp[i+3] = exp[i];
    exp[0] = 8'd5; exp[1] = 8'h11; exp[2] = 8'h22; expN += 3;
    sendPkt(); compare("R11");

    // seeded random mix
    for (int n = 0; n < 40; n++) begin
      logic [1:0] lm = 2'($urandom % 3);
      int pay;
      string tag;
      nodeAddr = 8'(1 + $urandom % 254);
      rssi = 8'($urandom); lqi = 7'($urandom);
      setCfg(lm, 8'd1, 2'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom));
      case ($urandom % 4)
        0: adrByte = nodeAddr;
        1: adrByte = 8'h00;
        2: adrByte = 8'hFF;
        default: adrByte = 8'($urandom);
      endcase
      if (lm == 2'd1) begin pktLen = 8'(1 + $urandom % 80); pay = $urandom % (pktLen + 6); tag = "R2"; end
      else if (lm == 2'd0) begin pktLen = 8'(1 + $urandom % 20); pay = 0; tag = "R5"; end
      else begin pay = 1 + $urandom % 10; tag = "R7"; end
      runCase(tag, pay, ($urandom % 3) == 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule